// File: doc/BRIEF.md
# Debug Single-Step and Halt Controller

This block gates instruction issue for a small processor core while a debugger is attached. It watches the core's issue and retire handshakes and holds a halted flag. A host "go" strobe clears that flag. In step mode the controller permits exactly one issue per go and halts once that instruction retires. In serialized mode it keeps instructions from overlapping, so that an address or data breakpoint is seen before the following instruction starts.

The controller also decides whether an interrupt request is accepted. While stepping, a mask bit can hide requests. It checks the privilege of a retiring HALT instruction and stops the core on a breakpoint in any mode. A breakpoint on the program counter stops the matching instruction before it issues. An address or data breakpoint stops the core on the following cycle. The core datapath is not part of this block.

Top module: `dbg_step_ctrl`

## Requirements
- R1: With `cfg_step` high, `halted` rises one cycle after a `retire_valid` pulse. After a go, `issue_ok` is granted for exactly one issue and is then low until the next go.
- R2: When `cfg_step` is high, the core is not halted, no step credit is held and nothing is in flight, `halted` rises on the next cycle.
- R3: A `go` pulse while `halted` is high clears `halted` on the next cycle. A `go` pulse while `halted` is low has no effect on `halted`.
- R4: `irq_take` equals `irq_req` while the core is running, unless `cfg_step` and `cfg_irq_mask` are both high. In that case it is 0. It is also 0 while `halted` is high.
- R5: A retiring HALT instruction (`retire_is_halt`=1) raises `halted` on the next cycle when `priv_user`=0, or when `priv_user`=1 and `cfg_user_halt_ok`=1.
- R6: A retiring HALT instruction with `priv_user`=1 and `cfg_user_halt_ok`=0 pulses `priv_viol` high for one cycle, on the next cycle. It does not raise `halted` on its own.
- R7: With `cfg_serial` high, `issue_ok` is low while any instruction is in flight. It stays low for the GAP_CYC (default 5) cycles that follow the cycle of a retire.
- R8: In a cycle where `issue_req` and `bkpt_pc` are both high, `issue_ok` is low, so the matching instruction never issues. `halted` rises on the next cycle.
- R9: A `bkpt_data` pulse raises `halted` on the next cycle in every mode.
- R10: `issue_ok` is low while `halted` is high. It is also low when MAX_FLIGHT (default 4) instructions are issued but not yet retired.
- R11: After reset, `halted` and `priv_viol` are 0. With `cfg_step` low, `issue_ok` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_step | input | 1 | Single-step mode enable |
| cfg_irq_mask | input | 1 | Ignore interrupt requests while stepping |
| cfg_user_halt_ok | input | 1 | Allow HALT in user mode |
| cfg_serial | input | 1 | Non-overlapped issue mode |
| issue_req | input | 1 | Core has an instruction ready to issue |
| issue_ok | output | 1 | Issue permitted this cycle (fires with issue_req) |
| retire_valid | input | 1 | One instruction retires this cycle |
| retire_is_halt | input | 1 | The retiring instruction is HALT |
| priv_user | input | 1 | Core is in user mode (0 = supervisor) |
| go | input | 1 | Host resume strobe |
| irq_req | input | 1 | Pending interrupt request |
| irq_take | output | 1 | Interrupt accepted |
| bkpt_pc | input | 1 | Instruction at issue matches a PC breakpoint |
| bkpt_data | input | 1 | Address or data breakpoint trigger |
| halted | output | 1 | Core halted under debug |
| priv_viol | output | 1 | Privilege violation pulse for a user HALT |

## Verification
The assertions check several things on every cycle:
- no issue is permitted while halted;
- a halt is sticky until go;
- a retire in step mode halts on the next cycle;
- a PC breakpoint suppresses its own issue and halts;
- a disallowed user HALT flags a violation without stopping the core;
- the in-flight count stays within bounds;
- a retire in serialized mode reloads the gap counter.

Other behaviour is shown only by the bench's scenarios:
- that exactly one instruction issues per go;
- that a go is ignored while running;
- the full length of the serialized gap;
- that interrupt masking follows the step mode and the mask bit.

// File: rtl/dbg_step_pkg.sv
package dbg_step_pkg;

    typedef struct packed {
        logic halted;
        logic credit;
        logic priv_viol;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{halted: 1'b0, credit: 1'b0, priv_viol: 1'b0};

endpackage

// File: rtl/dbg_flight_cnt.sv
module dbg_flight_cnt #(
    parameter int MAX_FLIGHT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic room,
    output logic empty
);
    localparam int CNT_W = $clog2(MAX_FLIGHT + 1);
    localparam logic [CNT_W-1:0] MAXV = CNT_W'(MAX_FLIGHT);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        unique case ({inc, dec})
            2'b10:   if (cnt_q < MAXV) cnt_d = cnt_q + ONE;
            2'b01:   if (cnt_q != '0)  cnt_d = cnt_q - ONE;
            default: cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign room  = (cnt_q < MAXV);
    assign empty = (cnt_q == '0);

    AST_FLIGHT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= MAXV); // R10

endmodule

// File: rtl/dbg_gap_timer.sv
module dbg_gap_timer #(
    parameter int GAP_CYC = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic idle
);
    generate
        if (GAP_CYC == 0) begin : g_nogap
            assign idle = 1'b1;
        end else begin : g_gap
            localparam int GW = $clog2(GAP_CYC + 1);
            localparam logic [GW-1:0] GAPV = GW'(GAP_CYC);
            localparam logic [GW-1:0] ONE  = GW'(1);

            logic [GW-1:0] gap_d, gap_q;

            always_comb begin
                gap_d = gap_q;
                if (load)               gap_d = GAPV;
                else if (gap_q != '0)   gap_d = gap_q - ONE;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) gap_q <= '0;
                else        gap_q <= gap_d;
            end

            assign idle = (gap_q == '0);

            AST_GAP_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
                load |=> (gap_q == GAPV)); // R7
        end
    endgenerate

endmodule

// File: rtl/dbg_step_ctrl.sv
module dbg_step_ctrl
    import dbg_step_pkg::*;
#(
    parameter int MAX_FLIGHT = 4,
    parameter int GAP_CYC    = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_step,
    input  logic cfg_irq_mask,
    input  logic cfg_user_halt_ok,
    input  logic cfg_serial,
    input  logic issue_req,
    output logic issue_ok,
    input  logic retire_valid,
    input  logic retire_is_halt,
    input  logic priv_user,
    input  logic go,
    input  logic irq_req,
    output logic irq_take,
    input  logic bkpt_pc,
    input  logic bkpt_data,
    output logic halted,
    output logic priv_viol
);
    ctl_state_t st_d, st_q;

    logic fl_room, fl_empty, gap_idle;
    logic issue_fire;
    logic gap_load;

    dbg_flight_cnt #(.MAX_FLIGHT(MAX_FLIGHT)) flight_i (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (issue_fire),
        .dec   (retire_valid),
        .room  (fl_room),
        .empty (fl_empty)
    );

    assign gap_load = retire_valid && cfg_serial;

    dbg_gap_timer #(.GAP_CYC(GAP_CYC)) gap_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (gap_load),
        .idle  (gap_idle)
    );

    logic serial_clear, step_clear, pc_hit, halt_instr_ok, halt_instr_bad, halt_req;

    always_comb begin
        serial_clear   = !cfg_serial || (fl_empty && gap_idle);
        step_clear     = !cfg_step || (st_q.credit && fl_empty);
        pc_hit         = issue_req && bkpt_pc;

        issue_ok       = !st_q.halted && !bkpt_pc && fl_room && serial_clear && step_clear;
        issue_fire     = issue_req && issue_ok;

        halt_instr_bad = retire_valid && retire_is_halt && priv_user && !cfg_user_halt_ok;
        halt_instr_ok  = retire_valid && retire_is_halt && (!priv_user || cfg_user_halt_ok);

        halt_req = pc_hit || bkpt_data || halt_instr_ok
                 || (cfg_step && retire_valid)
                 || (cfg_step && !st_q.credit && fl_empty);

        st_d = st_q;
        if (st_q.halted) st_d.halted = !go;
        else             st_d.halted = halt_req;

        if (!cfg_step)                st_d.credit = 1'b0;
        else if (st_q.halted && go)   st_d.credit = 1'b1;
        else if (issue_fire)          st_d.credit = 1'b0;

        st_d.priv_viol = halt_instr_bad;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CTL_RESET;
        else        st_q <= st_d;
    end

    assign halted    = st_q.halted;
    assign priv_viol = st_q.priv_viol;
    assign irq_take  = irq_req && !st_q.halted && !(cfg_step && cfg_irq_mask);

    AST_NO_ISSUE_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !issue_ok); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (halted && !go) |=> halted); // R3
    AST_STEP_RETIRE_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_step && retire_valid && !halted) |=> halted); // R1
    AST_PC_BKPT_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && bkpt_pc) |-> !issue_ok); // R8
    AST_PC_BKPT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_req && bkpt_pc && !halted) |=> halted); // R8
    AST_DATA_BKPT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        (bkpt_data && !halted) |=> halted); // R9
    AST_USER_HALT_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && retire_is_halt && priv_user && !cfg_user_halt_ok) |=> priv_viol); // R6
    AST_USER_HALT_NOSTOP: assert property (@(posedge clk) disable iff (!rst_n)
        (retire_valid && retire_is_halt && priv_user && !cfg_user_halt_ok
         && !cfg_step && !bkpt_data && !(issue_req && bkpt_pc) && !halted) |=> !halted); // R6
    AST_SERIAL_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_serial && retire_valid) |=> !issue_ok); // R7
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_step && cfg_irq_mask) |-> !irq_take); // R4

endmodule

// File: tb/dbg_step_ctrl_tb_top.sv
module dbg_step_ctrl_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_step = 0, cfg_irq_mask = 0, cfg_user_halt_ok = 0, cfg_serial = 0;
    logic issue_req = 0, retire_valid = 0, retire_is_halt = 0, priv_user = 0;
    logic go = 0, irq_req = 0, bkpt_pc = 0, bkpt_data = 0;
    logic issue_ok, irq_take, halted, priv_viol;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    dbg_step_ctrl dut_i (
        .clk(clk), .rst_n(rst_n),
        .cfg_step(cfg_step), .cfg_irq_mask(cfg_irq_mask),
        .cfg_user_halt_ok(cfg_user_halt_ok), .cfg_serial(cfg_serial),
        .issue_req(issue_req), .issue_ok(issue_ok),
        .retire_valid(retire_valid), .retire_is_halt(retire_is_halt),
        .priv_user(priv_user), .go(go), .irq_req(irq_req), .irq_take(irq_take),
        .bkpt_pc(bkpt_pc), .bkpt_data(bkpt_data),
        .halted(halted), .priv_viol(priv_viol)
    );

    // fields: step mask uhe serial | req ret is_halt user go irq | exp ok halted irq_take viol
    typedef logic [13:0] vec_t;
    localparam int NV = 19;
    localparam vec_t TBL [NV] = '{
        14'b1100_000000_0000,  // R2 entering step idle
        14'b1100_000001_0100,  // R2 halted, R4 no irq while halted
        14'b1100_000010_0100,  // R3 go while halted
        14'b1100_100001_1000,  // R1 one issue granted, R4 masked
        14'b1100_000000_0000,  // R1 no second issue
        14'b1100_010000_0000,  // R1 retire
        14'b1000_000011_0100,  // R1 halted after retire
        14'b1000_000001_1010,  // R4 unmasked step accepts irq
        14'b1000_100000_1000,  // R1 issue
        14'b1000_011100_0000,  // R6 user halt disallowed in step
        14'b1000_000000_0101,  // R6 violation pulse, R1 halted
        14'b0000_000010_0100,  // R3 resume
        14'b0000_100000_1000,  // R11 free running
        14'b0000_100000_1000,  // R10 second in flight
        14'b0000_010000_1000,
        14'b0000_011100_1000,  // R6 user halt disallowed
        14'b0000_000000_1001,  // R6 pulse, no halt
        14'b0000_000010_1000,  // R3 go while running
        14'b0000_000000_1000   // R3 go ignored
    };

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic nxt();
        @(negedge clk);
        issue_req = 0; retire_valid = 0; retire_is_halt = 0; priv_user = 0;
        go = 0; irq_req = 0; bkpt_pc = 0; bkpt_data = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0;
        cfg_step = 0; cfg_irq_mask = 0; cfg_user_halt_ok = 0; cfg_serial = 0;
        nxt();
        nxt();
        rst_n = 1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        do_reset();
        #1;
        chk("R11 halted after reset", halted, 1'b0);
        chk("R11 priv_viol after reset", priv_viol, 1'b0);
        chk("R11 issue_ok after reset", issue_ok, 1'b1);

        // table walk: drive at negedge, check 1ns later
        for (int i = 0; i < NV; i++) begin
            nxt();
            {cfg_step, cfg_irq_mask, cfg_user_halt_ok, cfg_serial} = TBL[i][13:10];
            {issue_req, retire_valid, retire_is_halt, priv_user, go, irq_req} = TBL[i][9:4];
            #1;
            chk($sformatf("R1/R4 row %0d issue_ok", i), issue_ok, TBL[i][3]);
            chk($sformatf("R1/R3 row %0d halted", i), halted, TBL[i][2]);
            chk($sformatf("R4 row %0d irq_take", i), irq_take, TBL[i][1]);
            chk($sformatf("R6 row %0d priv_viol", i), priv_viol, TBL[i][0]);
        end

        // R7 serialized issue gap
        do_reset();
        cfg_serial = 1;
        nxt(); issue_req = 1; #1;
        chk("R7 first issue", issue_ok, 1'b1);
        nxt(); #1;
        chk("R7 blocked in flight", issue_ok, 1'b0);
        nxt(); retire_valid = 1; #1;
        chk("R7 blocked at retire", issue_ok, 1'b0);
        for (int k = 0; k < 5; k++) begin
            nxt(); #1;
            chk($sformatf("R7 gap cycle %0d", k + 1), issue_ok, 1'b0);
        end
        nxt(); #1;
        chk("R7 gap expired", issue_ok, 1'b1);

        // R10 in-flight limit
        do_reset();
        for (int k = 0; k < 4; k++) begin
            nxt(); issue_req = 1; #1;
            chk($sformatf("R10 issue %0d", k), issue_ok, 1'b1);
        end
        nxt(); issue_req = 1; #1;
        chk("R10 limit reached", issue_ok, 1'b0);

        // R8 PC breakpoint
        do_reset();
        nxt(); issue_req = 1; bkpt_pc = 1; #1;
        chk("R8 matching issue blocked", issue_ok, 1'b0);
        nxt(); #1;
        chk("R8 halted", halted, 1'b1);
        chk("R10 no issue while halted", issue_ok, 1'b0);
        nxt(); go = 1;
        nxt(); #1;
        chk("R3 resumed", halted, 1'b0);

        // R9 data breakpoint in serialized mode
        cfg_serial = 1;
        nxt(); bkpt_data = 1; #1;
        chk("R9 not yet halted", halted, 1'b0);
        nxt(); #1;
        chk("R9 halted", halted, 1'b1);

        // R5 supervisor HALT and allowed user HALT
        do_reset();
        nxt(); issue_req = 1;
        nxt(); retire_valid = 1; retire_is_halt = 1; priv_user = 0;
        nxt(); #1;
        chk("R5 supervisor halt", halted, 1'b1);
        chk("R5 no violation", priv_viol, 1'b0);
        nxt(); go = 1;
        cfg_user_halt_ok = 1;
        nxt(); issue_req = 1; #1;
        chk("R3 running again", halted, 1'b0);
        nxt(); retire_valid = 1; retire_is_halt = 1; priv_user = 1;
        nxt(); #1;
        chk("R5 user halt allowed", halted, 1'b1);
        chk("R5 no violation user", priv_viol, 1'b0);

        summary();
    end

endmodule